// File: doc/BRIEF.md
# Pause Frame Handshake Controller

This block tells user logic that a pause frame has arrived and times the pause that follows. It has nine channels that run side by side and never interact. Channel 8 serves the global (whole-link) pause, and channels 7 down to 0 serve the eight priority classes. Upstream frame logic supplies a one-cycle received pulse per channel, together with that channel's 16-bit quanta value.

An enabled idle channel takes the pulse, raises its request flag and loads the quanta into a down-counter. In acknowledge-checking mode, the counter stays frozen until user logic raises that channel's acknowledge. The counter then steps down on a shared quanta-tick strobe, which is independent of the clock. When the counter reaches zero the request falls. In checking mode, the channel then waits for the acknowledge to drop. If it does not drop, the channel gives up after a fixed 32-cycle timeout.

The received pulse is an event, not a stream: it cannot be back-pressured. A pulse that lands on a busy or disabled channel is dropped. Enable, mode and acknowledge are plain level controls.

Top module: `pause_handshake_ctrl`

## Requirements
- R1: A received pulse on an idle channel whose enable bit is 1 sets that channel's request bit after the next clock edge and loads its quanta into the channel timer. Bit 8 of every 9-bit vector is the global channel, and bits 7..0 are the priority channels. The quanta for channel n sits at bits [16n+15:16n] of the quanta bus.
- R2: A received pulse on an idle channel whose enable bit is 0 is discarded. The channel stays idle and its request stays low.
- R3: The acknowledge-checking mode is sampled when a pulse is accepted. In checking mode the timer holds its value, whatever ticks arrive, until that channel's acknowledge is sampled high. Counting begins on the following cycle.
- R4: Outside checking mode, counting begins right after the load, with no wait for an acknowledge.
- R5: While counting, the timer drops by one on each clock edge at which the quanta tick is high. The request falls at the first edge at which the timer already holds zero. A quanta of q therefore ends one edge after the q-th tick, and a quanta of 0 ends one cycle after the request rose.
- R6: In checking mode, after the request falls, the channel returns to idle at the first edge at which its acknowledge is sampled low.
- R7: If the acknowledge stays high, the channel returns to idle at the 32nd edge after the request fell. A pulse at that edge is still dropped, and a pulse at the following edge is accepted.
- R8: Outside checking mode, the channel is idle as soon as the request falls, so a pulse at the very next edge is accepted.
- R9: Clearing a channel's enable bit while it is not idle does not cut the sequence short. The request still falls only when the timer expires, and the new enable value applies from idle onwards.
- R10: Pulses that arrive while a channel is not idle are dropped, and its timer is not reloaded.
- R11: Channels are independent. Pulses, ticks and acknowledges on one channel never change another channel's request timing.
- R12: A synchronous active-high reset returns every channel to idle with its request low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_vld | input | 9 | Per-channel one-cycle pause-received pulse |
| frame_quanta | input | 144 | Per-channel 16-bit quanta, channel n at [16n+15:16n] |
| chan_en | input | 9 | Per-channel enable |
| ack_check_mode | input | 1 | 1 = wait for acknowledge before and after the countdown |
| user_ack | input | 9 | Per-channel acknowledge from user logic |
| quanta_tick | input | 1 | Strobe; one pulse is one quanta time |
| pause_req | output | 9 | Per-channel pause request flag |

## Verification
The bound checker watches every channel on every cycle. It checks that an accepted pulse raises the request with the quanta loaded, and that a pulse on a disabled channel leaves it idle. It also checks that a waiting timer is frozen, that each tick removes exactly one count, and that an expired timer drops the request. Finally, it checks that the release phase never runs past 32 cycles, that a disabled channel still completes its sequence, and that reset clears every request.

Some behaviour needs a whole scenario from the bench rather than a per-cycle property. This covers the exact edge of the 32-cycle fallback, and the back-to-back acceptance that follows release. It also covers mode latching across a mid-sequence change of the mode input, and two channels running different quanta side by side.

// File: rtl/pause_pkg.sv
package pause_pkg;
  // Per-channel handshake phase.
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAITACK = 2'd1,
    ST_COUNT   = 2'd2,
    ST_RELEASE = 2'd3
  } chan_state_e;
endpackage

// File: rtl/pause_quanta_timer.sv
// Loadable down-counter holding the remaining pause quanta.
module pause_quanta_timer #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [QW-1:0] load_val,
  input  logic          dec,
  output logic [QW-1:0] value,
  output logic          is_zero
);
  logic [QW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign value   = cnt_q;
  assign is_zero = (cnt_q == '0);
endmodule

// File: rtl/pause_release_timer.sv
// Counts the cycles spent waiting for the acknowledge release.
module pause_release_timer #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/pause_chan_unit.sv
// One channel: accept, optional acknowledge wait, countdown, release.
module pause_chan_unit
  import pause_pkg::*;
#(
  parameter int QW           = 16,
  parameter int RELEASE_WAIT = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_vld,
  input  logic [QW-1:0] frame_quanta,
  input  logic          chan_en,
  input  logic          ack_check_mode,
  input  logic          user_ack,
  input  logic          quanta_tick,
  output logic          pause_req,
  output chan_state_e   state_o,
  output logic [QW-1:0] timer_o
);
  chan_state_e state_q;
  logic        chk_q;
  logic        req_q;
  logic        accept;
  logic        tmr_zero;
  logic        tmr_dec;
  logic        rel_done;

  // Enable is looked at only in idle, so a running sequence is never cut.
  assign accept  = (state_q == ST_IDLE) && frame_vld && chan_en;
  assign tmr_dec = (state_q == ST_COUNT) && quanta_tick && !tmr_zero;

  pause_quanta_timer #(.QW(QW)) u_qtmr (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (frame_quanta),
    .dec      (tmr_dec),
    .value    (timer_o),
    .is_zero  (tmr_zero)
  );

  pause_release_timer #(.LIMIT(RELEASE_WAIT)) u_rtmr (
    .clk  (clk),
    .rst  (rst),
    .run  (state_q == ST_RELEASE),
    .done (rel_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      chk_q   <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            req_q   <= 1'b1;
            chk_q   <= ack_check_mode;
            state_q <= ack_check_mode ? ST_WAITACK : ST_COUNT;
          end
        end
        ST_WAITACK: begin
          if (user_ack) state_q <= ST_COUNT;
        end
        ST_COUNT: begin
          if (tmr_zero) begin
            req_q   <= 1'b0;
            state_q <= chk_q ? ST_RELEASE : ST_IDLE;
          end
        end
        ST_RELEASE: begin
          if (!user_ack || rel_done) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pause_req = req_q;
  assign state_o   = state_q;
endmodule

// File: rtl/pause_handshake_ctrl.sv
// Nine-channel pause request/acknowledge controller (global + priorities).
module pause_handshake_ctrl
  import pause_pkg::*;
#(
  parameter int NUM_PRIO     = 8,
  parameter int QW           = 16,
  parameter int RELEASE_WAIT = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_PRIO:0]             frame_vld,
  input  logic [(NUM_PRIO+1)*QW-1:0]    frame_quanta,
  input  logic [NUM_PRIO:0]             chan_en,
  input  logic                          ack_check_mode,
  input  logic [NUM_PRIO:0]             user_ack,
  input  logic                          quanta_tick,
  output logic [NUM_PRIO:0]             pause_req
);
  localparam int NUM_CH = NUM_PRIO + 1;

  chan_state_e   ch_state [NUM_CH];
  logic [QW-1:0] ch_timer [NUM_CH];

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    pause_chan_unit #(
      .QW           (QW),
      .RELEASE_WAIT (RELEASE_WAIT)
    ) u_ch (
      .clk            (clk),
      .rst            (rst),
      .frame_vld      (frame_vld[n]),
      .frame_quanta   (frame_quanta[n*QW +: QW]),
      .chan_en        (chan_en[n]),
      .ack_check_mode (ack_check_mode),
      .user_ack       (user_ack[n]),
      .quanta_tick    (quanta_tick),
      .pause_req      (pause_req[n]),
      .state_o        (ch_state[n]),
      .timer_o        (ch_timer[n])
    );
  end
endmodule

// File: rtl/pause_handshake_chk.sv
module pause_handshake_chk
  import pause_pkg::*;
#(
  parameter int NUM_PRIO     = 8,
  parameter int QW           = 16,
  parameter int RELEASE_WAIT = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_PRIO:0]          frame_vld,
  input logic [(NUM_PRIO+1)*QW-1:0] frame_quanta,
  input logic [NUM_PRIO:0]          chan_en,
  input logic [NUM_PRIO:0]          user_ack,
  input logic                       quanta_tick,
  input logic [NUM_PRIO:0]          pause_req,
  input chan_state_e                ch_state [NUM_PRIO+1],
  input logic [QW-1:0]              ch_timer [NUM_PRIO+1]
);
  localparam int NUM_CH = NUM_PRIO + 1;

  assert_reset_clears_R12: assert property (@(posedge clk)
    rst |=> (pause_req == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    int rel_cnt;

    always_ff @(posedge clk) begin
      if (rst || ch_state[i] != ST_RELEASE) rel_cnt <= 0;
      else                                  rel_cnt <= rel_cnt + 1;
    end

    assert_accept_loads_R1: assert property (@(posedge clk) disable iff (rst)
      (ch_state[i] == ST_IDLE && frame_vld[i] && chan_en[i])
      |=> (pause_req[i] && ch_timer[i] == $past(frame_quanta[i*QW +: QW])));

    assert_disabled_drop_R2: assert property (@(posedge clk) disable iff (rst)
      (ch_state[i] == ST_IDLE && frame_vld[i] && !chan_en[i])
      |=> (ch_state[i] == ST_IDLE && !pause_req[i]));

    assert_wait_holds_R3: assert property (@(posedge clk) disable iff (rst)
      (ch_state[i] == ST_WAITACK && !user_ack[i])
      |=> (ch_state[i] == ST_WAITACK && $stable(ch_timer[i]) && pause_req[i]));

    assert_tick_decrement_R5: assert property (@(posedge clk) disable iff (rst)
      (ch_state[i] == ST_COUNT && quanta_tick && ch_timer[i] != '0)
      |=> (ch_timer[i] == $past(ch_timer[i]) - 1'b1));

    assert_expiry_drops_req_R5: assert property (@(posedge clk) disable iff (rst)
      (ch_state[i] == ST_COUNT && ch_timer[i] == '0) |=> !pause_req[i]);

    assert_release_bounded_R7: assert property (@(posedge clk) disable iff (rst)
      (ch_state[i] == ST_RELEASE) |-> (rel_cnt < RELEASE_WAIT));

    assert_no_abort_R9: assert property (@(posedge clk) disable iff (rst)
      (ch_state[i] != ST_IDLE && !chan_en[i])
      |=> (ch_state[i] != ST_IDLE || $past(ch_state[i]) == ST_COUNT
           || $past(ch_state[i]) == ST_RELEASE));

    assert_busy_no_reload_R10: assert property (@(posedge clk) disable iff (rst)
      (ch_state[i] == ST_COUNT && frame_vld[i] && !quanta_tick && ch_timer[i] != '0)
      |=> $stable(ch_timer[i]));
  end
endmodule

bind pause_handshake_ctrl pause_handshake_chk #(
  .NUM_PRIO     (NUM_PRIO),
  .QW           (QW),
  .RELEASE_WAIT (RELEASE_WAIT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .frame_vld    (frame_vld),
  .frame_quanta (frame_quanta),
  .chan_en      (chan_en),
  .user_ack     (user_ack),
  .quanta_tick  (quanta_tick),
  .pause_req    (pause_req),
  .ch_state     (ch_state),
  .ch_timer     (ch_timer)
);

// File: tb/sim_pause_handshake_ctrl.sv
module sim_pause_handshake_ctrl;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [8:0]   frame_vld = '0;
  logic [143:0] frame_quanta = '0;
  logic [8:0]   chan_en = '1;
  logic         ack_check_mode = 1'b0;
  logic [8:0]   user_ack = '0;
  logic         quanta_tick = 1'b0;
  logic [8:0]   pause_req;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pause_handshake_ctrl u0 (
    .clk(clk), .rst(rst), .frame_vld(frame_vld), .frame_quanta(frame_quanta),
    .chan_en(chan_en), .ack_check_mode(ack_check_mode), .user_ack(user_ack),
    .quanta_tick(quanta_tick), .pause_req(pause_req)
  );

  // One clock edge; inputs change and outputs are sampled 1 ns after it.
  task automatic clk1();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [8:0] exp);
    checks++;
    if (pause_req !== exp) begin
      errors++;
      $display("FAIL %s: pause_req=%h expected %h", tag, pause_req, exp);
    end
  endtask

  task automatic do_reset();
    frame_vld = '0; chan_en = '1; ack_check_mode = 1'b0;
    user_ack = '0; quanta_tick = 1'b0; frame_quanta = '0;
    rst = 1'b1; clk1(); clk1(); rst = 1'b0;
  endtask

  task automatic set_q(int ch, int q);
    frame_quanta[ch*16 +: 16] = 16'(q);
  endtask

  task automatic frames(logic [8:0] mask);
    frame_vld = mask; clk1(); frame_vld = '0;
  endtask

  task automatic tick();
    quanta_tick = 1'b1; clk1(); quanta_tick = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 reset state", 9'h000);
  endtask

  task automatic t_disabled();
    do_reset();
    chan_en = 9'h1F7;
    set_q(3, 5); frames(9'h008);
    chk("R2 disabled pulse dropped", 9'h000);
    tick(); tick();
    chk("R2 still idle", 9'h000);
    chan_en = '1;
    set_q(3, 0); frames(9'h008);
    chk("R1 enabled pulse raises request", 9'h008);
    clk1();
    chk("R5 zero quanta ends next cycle", 9'h000);
  endtask

  task automatic t_nocheck();
    do_reset();
    set_q(0, 3); frames(9'h001);
    chk("R4 request raised", 9'h001);
    tick(); tick(); tick();
    chk("R5 high until zero seen", 9'h001);
    clk1();
    chk("R5 falls edge after last tick", 9'h000);
    set_q(0, 1); frames(9'h001);
    chk("R8 accepted right after fall", 9'h001);
    tick(); clk1();
    chk("R8 second sequence done", 9'h000);
  endtask

  task automatic t_ackwait();
    do_reset();
    ack_check_mode = 1'b1;
    set_q(8, 2); frames(9'h100);
    chk("R1 global channel raised", 9'h100);
    ack_check_mode = 1'b0;
    for (int k = 0; k < 5; k++) tick();
    chk("R3 held without ack", 9'h100);
    user_ack[8] = 1'b1; clk1();
    tick(); tick();
    chk("R3 counts after ack", 9'h100);
    clk1();
    chk("R5 falls after ack countdown", 9'h000);
    set_q(8, 4); frames(9'h100);
    chk("R10 pulse in release dropped", 9'h000);
    user_ack[8] = 1'b0; clk1();
    set_q(8, 0); frames(9'h100);
    chk("R6 idle after ack release", 9'h100);
    clk1();
    chk("R4 mode off counts at once", 9'h000);
  endtask

  task automatic t_fallback();
    do_reset();
    ack_check_mode = 1'b1;
    set_q(2, 1); frames(9'h004);
    user_ack[2] = 1'b1; clk1();
    tick(); clk1();
    chk("R7 request fell", 9'h000);
    for (int k = 0; k < 31; k++) clk1();
    frames(9'h004);
    chk("R7 pulse at edge 32 dropped", 9'h000);
    frames(9'h004);
    chk("R7 pulse at edge 33 accepted", 9'h004);
  endtask

  task automatic t_enable_clear();
    do_reset();
    set_q(5, 2); frames(9'h020);
    chan_en[5] = 1'b0;
    tick();
    chk("R9 not aborted", 9'h020);
    tick(); clk1();
    chk("R9 ends at expiry", 9'h000);
    set_q(5, 3); frames(9'h020);
    chk("R9 new enable applies", 9'h000);
  endtask

  task automatic t_busy();
    do_reset();
    set_q(1, 3); frames(9'h002);
    tick();
    set_q(1, 50); frames(9'h002);
    chk("R10 still running", 9'h002);
    tick(); tick(); clk1();
    chk("R10 no reload", 9'h000);
  endtask

  task automatic t_parallel();
    do_reset();
    set_q(4, 1); set_q(6, 3); frames(9'h050);
    chk("R11 both raised", 9'h050);
    tick(); clk1();
    chk("R11 short channel done alone", 9'h040);
    tick(); tick(); clk1();
    chk("R11 long channel done", 9'h000);
  endtask

  task automatic t_reset_mid();
    do_reset();
    set_q(7, 9); frames(9'h080);
    chk("R1 priority 7 raised", 9'h080);
    rst = 1'b1; clk1(); rst = 1'b0;
    chk("R12 reset mid-sequence", 9'h000);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_disabled();
    t_nocheck();
    t_ackwait();
    t_fallback();
    t_enable_clear();
    t_busy();
    t_parallel();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule